// File: doc/BRIEF.md
# Inverting Latched Bus Register

This block is a narrow bidirectional buffer register placed between two data ports, A and B. Two source-select inputs decide which port feeds the storage. While the capture control is high the storage is transparent: the selected port's data passes straight to the outputs with no clock delay. It is also written into the storage on every clock edge. When the capture control goes low, the value present at the last edge is kept and presented from then on.

Both port outputs carry the bitwise inverse of the presented value, so a transfer from A to B is inverted and a transfer from B to A is inverted too. Tri-state pins are modelled as a data-out bus and an output-enable bit per port. Each port has its own disable. A shared expansion input turns both ports off at once, so several such registers can share one set of lines. Capture does not depend on any of the output controls.

Top module: `inv_bus_register`

## Requirements
- R1: With capture high, selA high and selB low, bOut equals the bitwise inverse of aIn in the same cycle, with no clock delay.
- R2: With capture high, selB high and selA low, aOut equals the bitwise inverse of bIn in the same cycle.
- R3: While capture is low, aOut and bOut keep their value whatever aIn, bIn, selA or selB do.
- R4: After capture falls, the outputs show the inverse of the data that was selected at the last rising clock edge with capture high.
- R5: aOutEn is high exactly when aDisable and expandOff are both low, and bOutEn is high exactly when bDisable and expandOff are both low. Each disable acts only on its own port.
- R6: While expandOff is high, aOutEn and bOutEn are both low, whatever the two disables are.
- R7: When selA and selB are both high or both low, the stored value does not change and the outputs keep the inverse of the stored value, even with capture high.
- R8: Capture works while outputs are disabled or expandOff is high. Data captured in that state appears once the outputs are enabled again.
- R9: A synchronous reset (rst high at a rising edge) clears the stored value to zero, so with capture low both aOut and bOut read all ones (4'hF at the default width). aOut and bOut always carry the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the storage updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the storage |
| aIn | input | WIDTH | Data arriving on port A |
| bIn | input | WIDTH | Data arriving on port B |
| selA | input | 1 | Select port A as source of the storage |
| selB | input | 1 | Select port B as source of the storage |
| latchOpen | input | 1 | Capture control: high = transparent, low = hold |
| aDisable | input | 1 | Turns port A's output off |
| bDisable | input | 1 | Turns port B's output off |
| expandOff | input | 1 | Turns both port outputs off |
| aOut | output | WIDTH | Inverted presented value driven toward port A |
| aOutEn | output | 1 | Output enable for port A |
| bOut | output | WIDTH | Inverted presented value driven toward port B |
| bOutEn | output | 1 | Output enable for port B |

## Verification
The only internal state is the stored word. If it is wrong, the error shows on both data outputs in the first cycle after capture falls, or at once while both selects are equal. While capture is high and a single source is selected, the bypass hides the storage. A corrupted capture therefore stays invisible until the cycle after capture drops, and the bench checks in that cycle. Enable errors are combinational and show in the same cycle as the control change.

// File: rtl/inv_bus_pkg.sv
package inv_bus_pkg;

  // Strobes passed from the control decoder to the datapath.
  typedef struct packed {
    logic capture;  // write storage this edge and bypass source to outputs
    logic pickB;    // source is port B (else port A)
    logic driveA;   // port A output enabled
    logic driveB;   // port B output enabled
  } xfer_strobe_t;

endpackage

// File: rtl/inv_bus_ctrl.sv
module inv_bus_ctrl
  import inv_bus_pkg::*;
(
  input  logic         selA,
  input  logic         selB,
  input  logic         latchOpen,
  input  logic         aDisable,
  input  logic         bDisable,
  input  logic         expandOff,
  output xfer_strobe_t strobe
);

  logic singleSource;

  // Exactly one source selected; both or neither means keep contents.
  assign singleSource = selA ^ selB;

  always_comb begin
    strobe.capture = latchOpen & singleSource;
    strobe.pickB   = selB & ~selA;
    strobe.driveA  = ~aDisable & ~expandOff;
    strobe.driveB  = ~bDisable & ~expandOff;
  end

endmodule

// File: rtl/inv_bus_datapath.sv
module inv_bus_datapath
  import inv_bus_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  xfer_strobe_t     strobe,
  output logic [WIDTH-1:0] aOut,
  output logic             aOutEn,
  output logic [WIDTH-1:0] bOut,
  output logic             bOutEn
);

  logic [WIDTH-1:0] stored;
  logic [WIDTH-1:0] srcWord;
  logic [WIDTH-1:0] viewWord;

  // Per-bit slice: source mux, transparent bypass, inversion.
  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    assign srcWord[i]  = strobe.pickB ? bIn[i] : aIn[i];
    assign viewWord[i] = strobe.capture ? srcWord[i] : stored[i];
    assign aOut[i]     = ~viewWord[i];
    assign bOut[i]     = ~viewWord[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stored <= '0;
    end else if (strobe.capture) begin
      stored <= srcWord;
    end
  end

  assign aOutEn = strobe.driveA;
  assign bOutEn = strobe.driveB;

endmodule

// File: rtl/inv_bus_register.sv
module inv_bus_register
  import inv_bus_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  logic             selA,
  input  logic             selB,
  input  logic             latchOpen,
  input  logic             aDisable,
  input  logic             bDisable,
  input  logic             expandOff,
  output logic [WIDTH-1:0] aOut,
  output logic             aOutEn,
  output logic [WIDTH-1:0] bOut,
  output logic             bOutEn
);

  xfer_strobe_t strobe;

  inv_bus_ctrl u_ctrl (
    .selA      (selA),
    .selB      (selB),
    .latchOpen (latchOpen),
    .aDisable  (aDisable),
    .bDisable  (bDisable),
    .expandOff (expandOff),
    .strobe    (strobe)
  );

  inv_bus_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .aIn    (aIn),
    .bIn    (bIn),
    .strobe (strobe),
    .aOut   (aOut),
    .aOutEn (aOutEn),
    .bOut   (bOut),
    .bOutEn (bOutEn)
  );

endmodule

// File: rtl/inv_bus_register_chk.sv
module inv_bus_register_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] aIn,
  input logic [WIDTH-1:0] bIn,
  input logic             selA,
  input logic             selB,
  input logic             latchOpen,
  input logic             aDisable,
  input logic             bDisable,
  input logic             expandOff,
  input logic [WIDTH-1:0] aOut,
  input logic             aOutEn,
  input logic [WIDTH-1:0] bOut,
  input logic             bOutEn
);

  p_flow_a_to_b_r1: assert property (@(posedge clk) disable iff (rst)
    (latchOpen && selA && !selB) |-> (bOut == ~aIn));

  p_flow_b_to_a_r2: assert property (@(posedge clk) disable iff (rst)
    (latchOpen && selB && !selA) |-> (aOut == ~bIn));

  p_hold_closed_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(latchOpen) && !latchOpen) |-> ($stable(aOut) && $stable(bOut)));

  p_capture_last_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(latchOpen && selA && !selB) && !latchOpen) |-> (bOut == ~$past(aIn)));

  p_expand_off_r6: assert property (@(posedge clk) disable iff (rst)
    expandOff |-> (!aOutEn && !bOutEn));

  p_port_a_enable_r5: assert property (@(posedge clk) disable iff (rst)
    (!aDisable && !expandOff) |-> aOutEn);

  p_ambiguous_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (selA == selB) && (($past(selA) == $past(selB)) || !$past(latchOpen)))
      |-> $stable(aOut));

  p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !(latchOpen && (selA != selB))) |-> (aOut == '1));

  p_ports_match_r9: assert property (@(posedge clk) disable iff (rst)
    aOut == bOut);

endmodule

bind inv_bus_register inv_bus_register_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/inv_bus_register_tb.sv
module inv_bus_register_tb;

  localparam int PERIOD = 10;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] aIn = '0;
  logic [W-1:0] bIn = '0;
  logic         selA = 1'b0;
  logic         selB = 1'b0;
  logic         latchOpen = 1'b0;
  logic         aDisable = 1'b0;
  logic         bDisable = 1'b0;
  logic         expandOff = 1'b0;
  logic [W-1:0] aOut;
  logic         aOutEn;
  logic [W-1:0] bOut;
  logic         bOutEn;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  inv_bus_register #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .aIn(aIn), .bIn(bIn), .selA(selA), .selB(selB),
    .latchOpen(latchOpen), .aDisable(aDisable), .bDisable(bDisable),
    .expandOff(expandOff), .aOut(aOut), .aOutEn(aOutEn), .bOut(bOut), .bOutEn(bOutEn)
  );

  typedef struct packed {
    int unsigned req;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic sA;
    logic sB;
    logic lat;
    logic dA;
    logic dB;
    logic ex;
    logic [W-1:0] expOut;
    logic expAEn;
    logic expBEn;
  } vec_t;

  localparam int NVEC = 17;
  // Stored value starts at 0 after reset; each row is applied for one clock.
  localparam vec_t TBL [NVEC] = '{
    '{1, 4'h3, 4'h0, 1, 0, 1, 0, 0, 0, 4'hC, 1, 1},  // R1 A->B flow
    '{1, 4'h5, 4'h0, 1, 0, 1, 0, 0, 0, 4'hA, 1, 1},  // R1
    '{2, 4'h0, 4'h9, 0, 1, 1, 0, 0, 0, 4'h6, 1, 1},  // R2 B->A flow
    '{2, 4'h0, 4'h0, 0, 1, 1, 0, 0, 0, 4'hF, 1, 1},  // R2
    '{2, 4'h0, 4'hE, 0, 1, 1, 0, 0, 0, 4'h1, 1, 1},  // R2 stores E
    '{3, 4'h7, 4'h0, 1, 0, 0, 0, 0, 0, 4'h1, 1, 1},  // R3 hold
    '{3, 4'h0, 4'h2, 0, 1, 0, 0, 0, 0, 4'h1, 1, 1},  // R3 hold
    '{5, 4'h0, 4'h2, 0, 1, 0, 1, 0, 0, 4'h1, 0, 1},  // R5 A off only
    '{5, 4'h0, 4'h2, 0, 1, 0, 0, 1, 0, 4'h1, 1, 0},  // R5 B off only
    '{5, 4'h0, 4'h2, 0, 1, 0, 1, 1, 0, 4'h1, 0, 0},  // R5 both off
    '{6, 4'h0, 4'h2, 0, 1, 0, 0, 0, 1, 4'h1, 0, 0},  // R6 expansion
    '{8, 4'h6, 4'h0, 1, 0, 1, 0, 0, 1, 4'h9, 0, 0},  // R8 capture while off
    '{8, 4'h0, 4'h0, 1, 0, 0, 0, 0, 0, 4'h9, 1, 1},  // R8 visible again
    '{7, 4'hF, 4'hF, 1, 1, 1, 0, 0, 0, 4'h9, 1, 1},  // R7 both selects
    '{7, 4'h0, 4'h0, 0, 0, 1, 0, 0, 0, 4'h9, 1, 1},  // R7 no select
    '{4, 4'h1, 4'h0, 1, 0, 1, 0, 0, 0, 4'hE, 1, 1},  // R4 capture 1
    '{4, 4'h8, 4'h0, 1, 0, 0, 0, 0, 0, 4'hE, 1, 1}   // R4 held after fall
  };

  task automatic check(input int unsigned req, input string what,
                       input logic [W-1:0] gotA, input logic [W-1:0] gotB,
                       input logic gotAEn, input logic gotBEn,
                       input logic [W-1:0] expOut, input logic expAEn, input logic expBEn);
    total++;
    if (gotA !== expOut || gotB !== expOut || gotAEn !== expAEn || gotBEn !== expBEn) begin
      bad++;
      $display("FAIL R%0d %s: got aOut=%h bOut=%h aEn=%b bEn=%b expected out=%h aEn=%b bEn=%b",
               req, what, gotA, gotB, gotAEn, gotBEn, expOut, expAEn, expBEn);
    end
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic sA,
                       input logic sB, input logic lat, input logic dA, input logic dB,
                       input logic ex);
    aIn = a; bIn = b; selA = sA; selB = sB; latchOpen = lat;
    aDisable = dA; bDisable = dB; expandOff = ex;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    drive('0, '0, 0, 0, 0, 0, 0, 0);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #(PERIOD/4);
    // R9: cleared storage reads all ones on both ports
    check(9, "reset state", aOut, bOut, aOutEn, bOutEn, 4'hF, 1, 1);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      drive(TBL[i].a, TBL[i].b, TBL[i].sA, TBL[i].sB, TBL[i].lat,
            TBL[i].dA, TBL[i].dB, TBL[i].ex);
      #(PERIOD/4);
      check(TBL[i].req, $sformatf("vector %0d", i), aOut, bOut, aOutEn, bOutEn,
            TBL[i].expOut, TBL[i].expAEn, TBL[i].expBEn);
    end

    // R3: closed latch ignores source changes over several cycles
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      drive(4'(k * 5), 4'(k * 3), k[0], ~k[0], 0, 0, 0, 0);
      #(PERIOD/4);
      check(3, "hold with toggling inputs", aOut, bOut, aOutEn, bOutEn, 4'hE, 1, 1);
    end

    // R6: expansion overrides both disables being low and high
    @(negedge clk);
    drive('0, '0, 0, 0, 0, 1, 0, 1);
    #(PERIOD/4);
    check(6, "expansion with A disabled", aOut, bOut, aOutEn, bOutEn, 4'hE, 0, 0);

    // R9: reset while transparent clears storage
    @(negedge clk);
    drive(4'h4, '0, 1, 0, 1, 0, 0, 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    drive('0, '0, 0, 0, 0, 0, 0, 0);
    #(PERIOD/4);
    check(9, "mid-run reset", aOut, bOut, aOutEn, bOutEn, 4'hF, 1, 1);

    // R2 then R4: capture from B, hold after capture falls
    @(negedge clk);
    drive('0, 4'hB, 0, 1, 1, 0, 0, 0);
    #(PERIOD/4);
    check(2, "B flow", aOut, bOut, aOutEn, bOutEn, 4'h4, 1, 1);
    @(negedge clk);
    drive('0, 4'h3, 0, 1, 0, 0, 0, 0);
    #(PERIOD/4);
    check(4, "B capture held", aOut, bOut, aOutEn, bOutEn, 4'h4, 1, 1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule